// File: doc/BRIEF.md
# Receive Character Queue with Data and Time-out Interrupts

This block sits between the bit-level receiver of an asynchronous serial port and the host side. Each received character, together with its error flags, is written into a sixteen-entry queue when the receiver raises its valid strobe. A host or DMA engine removes characters with a one-cycle read strobe. The head of the queue is always visible on the read data port. When the queue is empty, the port shows the last character that was read.

Three indications come from the queue state. The data-ready bit is high whenever at least one character is held. The receive-data interrupt is high while the occupancy is at or above a threshold chosen by a 2-bit selector. The time-out interrupt covers the case where fewer characters than the threshold sit unread. It is raised after four character times with neither a new arrival nor a read. The length of that window follows the word-length setting. Bit times are counted from a 16x baud tick.

With the queue disabled, the block acts as a single holding register. In that mode the threshold is one and the time-out never fires. A receiver-reset input flushes the queue and the time-out state.

Top module: `rx_fifo_irq_ctrl`

## Requirements
- R1: After reset the occupancy is 0, and data-ready, receive-data interrupt, time-out interrupt and overrun are all 0.
- R2: Characters (8-bit data with its 3-bit error field) are read out in the order they were accepted. The head entry is shown on `rd_char`/`rd_err` while the queue holds data.
- R3: `data_ready` is 1 exactly while the occupancy is non-zero. It rises after a write into an empty queue and falls after the read that empties it.
- R4: `rx_data_irq` is 1 while occupancy ≥ threshold, where `trig_sel` code 0, 1, 2, 3 selects 1, 4, 8, 14 characters. It drops once a read takes the occupancy below the threshold.
- R5: With the queue enabled, depth is 16. A write into a full queue is discarded, the occupancy stays 16, and `overrun` is high for exactly the one cycle after that write.
- R6: A read of an empty queue leaves the occupancy at 0 and keeps `rd_char` at the last character read.
- R7: `timeout_irq` rises when data is held and 4 character times pass with no write and no read. One bit time is 16 baud ticks, and `wlen_sel` code 0, 1, 2, 3 (5 to 8 data bits) gives windows of 32, 36, 40 and 44 bit times.
- R8: An asserted time-out interrupt is cleared by a single read, by a new received character, or by receiver reset.
- R9: Before expiry, each accepted write or read restarts the time-out window from zero.
- R10: With `fifo_en` low the block holds one character. A second write is discarded with an overrun pulse, the threshold is 1, and the time-out interrupt never asserts.
- R11: While `rcvr_rst` is high, the queue is emptied and the time-out state cleared on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Received-character valid strobe |
| rx_char | input | 8 | Received character data |
| rx_err | input | 3 | Error flags stored with the character |
| rd_pop | input | 1 | Read strobe, removes the head entry |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Receive-data threshold code |
| wlen_sel | input | 2 | Word-length code (5 to 8 data bits) |
| rcvr_rst | input | 1 | Receiver reset, flushes the queue |
| baud_tick16 | input | 1 | 16x baud tick enable |
| rd_char | output | 8 | Head character, or last read character when empty |
| rd_err | output | 3 | Error flags of the head entry |
| occupancy | output | 5 | Number of characters held |
| data_ready | output | 1 | At least one character held |
| rx_data_irq | output | 1 | Occupancy at or above threshold |
| timeout_irq | output | 1 | Character time-out interrupt |
| overrun | output | 1 | One-cycle pulse when a write was discarded |

## Verification
A wrong pointer or count shows up at the next read. A read pointer that is off by one produces a wrong character on `rd_char` in the same cycle the scoreboard compares it. A wrong count shows up on `occupancy` and `data_ready` one clock after the write or read that caused it. A wrong time-out window or a wrong restart rule shifts the rising edge of `timeout_irq` by at least 64 clock cycles. The bench brackets each expiry 8 cycles on either side of the expected edge, so such a shift is caught on the first character that waits in the queue.

// File: rtl/rxfi_pkg.sv
package rxfi_pkg;
    localparam int WIN_W      = 6;
    localparam int BIT_TICKS  = 16;

    // threshold in characters for a selector code; single-register mode forces 1
    function automatic int unsigned trig_level(input logic [1:0] sel, input logic en);
        int unsigned lvl;
        case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = 14;
        endcase
        return en ? lvl : 1;
    endfunction

    // four character times in bit periods: 4 * (start + data + parity + stop)
    function automatic logic [WIN_W-1:0] window_bits(input logic [1:0] wl);
        logic [WIN_W-1:0] char_bits;
        char_bits = {{(WIN_W-2){1'b0}}, wl} + WIN_W'(8);
        return char_bits << 2;
    endfunction
endpackage

// File: rtl/rxfi_store.sv
module rxfi_store #(
    parameter int DEPTH  = 16,
    parameter int ENT_W  = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cap_one,
    input  logic             push,
    input  logic [ENT_W-1:0] wdata,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             ovr,
    output logic             pushed,
    output logic             popped
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
        logic [ENT_W-1:0]            last;
        logic                        ovr;
    } store_t;

    store_t s_d, s_q;
    logic   full;

    always_comb begin
        s_d    = s_q;
        full   = cap_one ? (s_q.cnt != '0) : (s_q.cnt == CNT_W'(DEPTH));
        pushed = push && !full;
        popped = pop && (s_q.cnt != '0);
        if (flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
            s_d.ovr = 1'b0;
            pushed  = 1'b0;
            popped  = 1'b0;
        end else begin
            s_d.ovr = push && full;
            if (pushed) begin
                s_d.mem[s_q.wr] = wdata;
                s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
            end
            if (popped) begin
                s_d.last = s_q.mem[s_q.rd];
                s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
            end
            if (pushed && !popped) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (popped && !pushed) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = (s_q.cnt != '0) ? s_q.mem[s_q.rd] : s_q.last;
    assign count = s_q.cnt;
    assign ovr   = s_q.ovr;
endmodule

// File: rtl/rxfi_tmo.sv
module rxfi_tmo
    import rxfi_pkg::*;
#(
    parameter int TICKS  = BIT_TICKS,
    localparam int SUB_W = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [WIN_W-1:0] window,
    output logic             expired
);
    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [WIN_W-1:0] bits;
        logic             irq;
    } tmo_t;

    tmo_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart || !run) begin
            t_d = '0;
        end else begin
            if (tick && (t_q.bits < window)) begin
                if (t_q.sub == SUB_W'(TICKS - 1)) begin
                    t_d.sub  = '0;
                    t_d.bits = t_q.bits + 1'b1;
                end else begin
                    t_d.sub = t_q.sub + 1'b1;
                end
            end
            if (t_q.bits >= window) begin
                t_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = t_q.irq;
endmodule

// File: rtl/rx_fifo_irq_ctrl.sv
module rx_fifo_irq_ctrl
    import rxfi_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 8,
    parameter int ERR_W   = 3,
    localparam int ENT_W  = DATA_W + ERR_W,
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_char,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              rd_pop,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        wlen_sel,
    input  logic              rcvr_rst,
    input  logic              baud_tick16,
    output logic [DATA_W-1:0] rd_char,
    output logic [ERR_W-1:0]  rd_err,
    output logic [OCC_W-1:0]  occupancy,
    output logic              data_ready,
    output logic              rx_data_irq,
    output logic              timeout_irq,
    output logic              overrun
);
    logic [ENT_W-1:0] head;
    logic [OCC_W-1:0] cnt;
    logic             pushed;
    logic             popped;
    logic [OCC_W-1:0] level;

    rxfi_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (rcvr_rst),
        .cap_one(!fifo_en),
        .push   (rx_push),
        .wdata  ({rx_err, rx_char}),
        .pop    (rd_pop),
        .head   (head),
        .count  (cnt),
        .ovr    (overrun),
        .pushed (pushed),
        .popped (popped)
    );

    rxfi_tmo u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(rcvr_rst || pushed || popped || rx_push),
        .run    (fifo_en && (cnt != '0)),
        .tick   (baud_tick16),
        .window (window_bits(wlen_sel)),
        .expired(timeout_irq)
    );

    always_comb begin
        level = OCC_W'(trig_level(trig_sel, fifo_en));
    end

    assign {rd_err, rd_char} = head;
    assign occupancy   = cnt;
    assign data_ready  = (cnt != '0);
    assign rx_data_irq = (cnt >= level);
endmodule

// File: rtl/rxfi_checker.sv
module rxfi_checker #(
    parameter int DEPTH  = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             rd_pop,
    input logic             fifo_en,
    input logic             rcvr_rst,
    input logic [OCC_W-1:0] occupancy,
    input logic             data_ready,
    input logic             timeout_irq,
    input logic             overrun
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= OCC_W'(DEPTH)); // R5

    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && occupancy == OCC_W'(DEPTH) && rx_push && !rd_pop && !rcvr_rst)
        |=> (overrun && occupancy == OCC_W'(DEPTH))); // R5

    AST_DR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_push)); // R3

    AST_TMO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> (data_ready && fifo_en)); // R7

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_irq && (rx_push || rd_pop || rcvr_rst)) |=> !timeout_irq); // R8

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rcvr_rst |=> (occupancy == '0 && !timeout_irq)); // R11

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && occupancy == OCC_W'(1) && rx_push && !rd_pop && !rcvr_rst)
        |=> (occupancy == OCC_W'(1) && overrun)); // R10
endmodule

bind rx_fifo_irq_ctrl rxfi_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_push    (rx_push),
    .rd_pop     (rd_pop),
    .fifo_en    (fifo_en),
    .rcvr_rst   (rcvr_rst),
    .occupancy  (occupancy),
    .data_ready (data_ready),
    .timeout_irq(timeout_irq),
    .overrun    (overrun)
);

// File: tb/rx_fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module rx_fifo_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic [2:0] rx_err = '0;
    logic       rd_pop = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] wlen_sel = 2'd3;
    logic       rcvr_rst = 1'b0;
    logic       baud_tick16 = 1'b1;
    logic [7:0] rd_char;
    logic [2:0] rd_err;
    logic [4:0] occupancy;
    logic       data_ready, rx_data_irq, timeout_irq, overrun;

    int n_chk = 0;
    int n_bad = 0;
    logic [10:0] exp_q[$];
    logic [7:0]  last_rd = '0;

    always #2.5 clk = ~clk;

    rx_fifo_irq_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: compare the head entry against the scoreboard when a read is pending
    always @(negedge clk) begin
        if (rst_n && rd_pop && !rcvr_rst && exp_q.size() != 0) begin
            logic [10:0] e;
            e = exp_q.pop_front();
            chk("R2 read order", {21'd0, rd_err, rd_char}, {21'd0, e});
            last_rd = e[7:0];
        end
    end

    task automatic push(input logic [10:0] v);
        @(posedge clk); #1;
        rx_push = 1'b1;
        {rx_err, rx_char} = v;
        if (exp_q.size() < (fifo_en ? 16 : 1)) exp_q.push_back(v);
        @(posedge clk); #1;
        rx_push = 1'b0;
    endtask

    task automatic pop();
        @(posedge clk); #1;
        rd_pop = 1'b1;
        @(posedge clk); #1;
        rd_pop = 1'b0;
    endtask

    task automatic flush();
        @(posedge clk); #1;
        rcvr_rst = 1'b1;
        @(posedge clk); #1;
        rcvr_rst = 1'b0;
        exp_q.delete();
    endtask

    task automatic drain();
        while (exp_q.size() != 0) pop();
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int winbits(input int wl);
        return 4 * (wl + 8);
    endfunction

    function automatic int trig_of(input int s);
        case (s)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 occupancy", occupancy, 0);
        chk("R1 data_ready", data_ready, 0);
        chk("R1 rx_data_irq", rx_data_irq, 0);
        chk("R1 timeout_irq", timeout_irq, 0);
        chk("R1 overrun", overrun, 0);

        // R3 data-ready follows occupancy
        push(11'h155);
        @(negedge clk);
        chk("R3 ready after push", data_ready, 1);
        chk("R3 occupancy 1", occupancy, 1);
        pop();
        @(negedge clk);
        chk("R3 ready after empty", data_ready, 0);

        // R4 thresholds for each selector code
        for (int s = 0; s < 4; s++) begin
            int lvl;
            lvl = trig_of(s);
            flush();
            trig_sel = 2'(s);
            for (int i = 1; i <= lvl; i++) begin
                push(11'((s << 8) | i));
                @(negedge clk);
                if (i == lvl - 1) chk("R4 below threshold", rx_data_irq, 0);
                if (i == lvl)     chk("R4 at threshold", rx_data_irq, 1);
            end
            pop();
            @(negedge clk);
            chk("R4 drop below threshold", rx_data_irq, 0);
            drain();
        end
        trig_sel = 2'd0;

        // R5 overflow and R2 ordering over a full queue
        flush();
        for (int i = 0; i < 16; i++) push(11'(12'h700 + i * 7));
        @(negedge clk);
        chk("R5 full occupancy", occupancy, 16);
        push(11'h0ee);
        @(negedge clk);
        chk("R5 overrun pulse", overrun, 1);
        chk("R5 occupancy held", occupancy, 16);
        @(negedge clk);
        chk("R5 overrun one cycle", overrun, 0);
        drain();

        // R6 read of an empty queue
        @(negedge clk);
        chk("R6 empty", occupancy, 0);
        pop();
        @(negedge clk);
        chk("R6 occupancy stays 0", occupancy, 0);
        chk("R6 last char kept", rd_char, last_rd);

        // R7 window per word length, R8 clear by read
        for (int w = 0; w < 4; w++) begin
            int win;
            win = winbits(w) * 16;
            flush();
            wlen_sel = 2'(w);
            push(11'(12'h300 + w));
            wait_cyc(win - 9);
            chk("R7 not yet expired", timeout_irq, 0);
            wait_cyc(16);
            chk("R7 expired", timeout_irq, 1);
            pop();
            @(negedge clk);
            chk("R8 cleared by read", timeout_irq, 0);
        end

        // R8 clear by new character, then R11 by receiver reset
        wlen_sel = 2'd0;
        flush();
        push(11'h011);
        wait_cyc(winbits(0) * 16 + 8);
        chk("R7 expired before push", timeout_irq, 1);
        push(11'h022);
        @(negedge clk);
        chk("R8 cleared by new char", timeout_irq, 0);
        chk("R8 occupancy 2", occupancy, 2);
        wait_cyc(winbits(0) * 16 + 8);
        chk("R8 expired again", timeout_irq, 1);
        flush();
        @(negedge clk);
        chk("R11 flush timeout", timeout_irq, 0);
        chk("R11 flush occupancy", occupancy, 0);

        // R9 restart by a write before expiry
        push(11'h033);
        wait_cyc(winbits(0) * 8);
        push(11'h044);
        wait_cyc(winbits(0) * 16 - 9);
        chk("R9 window restarted", timeout_irq, 0);
        wait_cyc(16);
        chk("R9 expiry after restart", timeout_irq, 1);
        drain();

        // R10 single holding register mode
        fifo_en = 1'b0;
        trig_sel = 2'd3;
        flush();
        push(11'h0a5);
        @(negedge clk);
        chk("R10 threshold is one", rx_data_irq, 1);
        push(11'h05a);
        @(negedge clk);
        chk("R10 second write overrun", overrun, 1);
        chk("R10 holds one", occupancy, 1);
        wait_cyc(44 * 16 + 50);
        chk("R10 no timeout", timeout_irq, 0);
        drain();
        @(negedge clk);
        chk("R10 read out first char", rd_char, 8'ha5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule